// File: doc/BRIEF.md
# Triggered Phase Accumulator Oscillator

This block is the phase generator of one oscillator channel. A 32-bit accumulator adds the frequency word once per DAC clock and wraps modulo 2^32. A 16-bit phase offset is added to the upper half of the accumulator to form the output phase word. The output phase word and the current amplitude leave the block through registers. The sine lookup and the DAC datapath sit downstream and are outside this block.

Frequency, phase and amplitude can each come from a sample stream or from a register shadow. A per-group flag selects the source. A trigger reloads every parameter that is not streamed from its shadow. The trigger is either an external pulse or a streamed phase/amplitude sample whose amplitude is zero and whose phase bit 0 is 1. When auto-reset is enabled, the trigger also clears the accumulator. The accumulator then stays at zero until the amplitude register becomes non-zero. This gives chirps a repeatable starting phase.

Top module: `trig_nco`

## Requirements
- R1: While `rst` is high and at the first edge after it, every parameter, the accumulator and both outputs are zero. This is the state of a freshly enabled channel.
- R2: Each clock while not held, the accumulator adds the frequency register modulo 2^32. `phase_out` shows the accumulator value from before the edge, with the offset added.
- R3: `phase_out` equals accumulator bits [31:16] plus the phase register, modulo 2^16.
- R4: On a trigger, each parameter group whose streamed flag is 0 loads its shadow. The groups are frequency, and phase with amplitude. A group whose flag is 1 keeps its streamed value.
- R5: A streamed group takes `freq_in` when `freq_vld` is high, or `phase_in` and `amp_in` when `pa_vld` is high. A group that is not streamed ignores these inputs.
- R6: A trigger with `auto_rst_en` high sets the accumulator to zero at that edge.
- R7: After such a clear, the accumulator stays at zero for as long as the amplitude register is zero. It advances again at the first edge where the amplitude register is non-zero.
- R8: A streamed phase/amplitude sample acts as a trigger when `amp_in` is zero and `phase_in[0]` is 1. With `phase_in[0]` at 0 it does not trigger.
- R9: A trigger with `auto_rst_en` low changes only the parameters. The accumulator keeps counting.
- R10: `amp_out` equals the amplitude register as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_in | input | 32 | Streamed frequency word |
| freq_vld | input | 1 | Streamed frequency sample valid |
| phase_in | input | 16 | Streamed phase offset |
| amp_in | input | 15 | Streamed amplitude |
| pa_vld | input | 1 | Streamed phase/amplitude sample valid |
| trig_in | input | 1 | External trigger pulse |
| auto_rst_en | input | 1 | Clear accumulator on trigger |
| freq_shadow | input | 32 | Frequency register shadow |
| phase_shadow | input | 16 | Phase register shadow |
| amp_shadow | input | 15 | Amplitude register shadow |
| freq_streamed | input | 1 | Frequency comes from the stream |
| pa_streamed | input | 1 | Phase and amplitude come from the stream |
| phase_out | output | 16 | Output phase word |
| amp_out | output | 15 | Output amplitude |

## Verification
A sample or trigger applied before edge k updates the parameter registers and the accumulator at edge k. The outputs reflect those new values at edge k+1, and the phase word also shows the accumulator advance made at edge k+1 only one edge later. The bench drives inputs on the falling edge and updates an arithmetic model at each rising edge from the same inputs. It compares both outputs just after the following falling edge, so every check lands exactly two register stages after the stimulus. Closed-form checks after long runs confirm the wrap and the one-cycle offset.

// File: rtl/trig_nco.sv
module trig_nco #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 16,
  parameter int AMP_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] freq_in,
  input  logic             freq_vld,
  input  logic [PH_W-1:0]  phase_in,
  input  logic [AMP_W-1:0] amp_in,
  input  logic             pa_vld,
  input  logic             trig_in,
  input  logic             auto_rst_en,
  input  logic [ACC_W-1:0] freq_shadow,
  input  logic [PH_W-1:0]  phase_shadow,
  input  logic [AMP_W-1:0] amp_shadow,
  input  logic             freq_streamed,
  input  logic             pa_streamed,
  output logic [PH_W-1:0]  phase_out,
  output logic [AMP_W-1:0] amp_out
);

  logic [ACC_W-1:0] acc_q, freq_q;
  logic [PH_W-1:0]  ph_q;
  logic [AMP_W-1:0] amp_q;
  logic             hold_q;
  logic             pa_take, strm_trig, trig_w, clr, run;

  assign pa_take   = pa_streamed & pa_vld;
  assign strm_trig = pa_take & (amp_in == '0) & phase_in[0];
  assign trig_w    = trig_in | strm_trig;
  assign clr       = trig_w & auto_rst_en;
  assign run       = !hold_q || (amp_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q <= '0;
    end else if (freq_streamed) begin
      if (freq_vld) freq_q <= freq_in;
    end else if (trig_w) begin
      freq_q <= freq_shadow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      amp_q <= '0;
    end else if (pa_streamed) begin
      if (pa_vld) begin
        ph_q  <= phase_in;
        amp_q <= amp_in;
      end
    end else if (trig_w) begin
      ph_q  <= phase_shadow;
      amp_q <= amp_shadow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      if (clr)      acc_q <= '0;
      else if (run) acc_q <= acc_q + freq_q;
      if (clr)                hold_q <= 1'b1;
      else if (amp_q != '0)   hold_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_out <= '0;
      amp_out   <= '0;
    end else begin
      phase_out <= acc_q[ACC_W-1 -: PH_W] + ph_q;
      amp_out   <= amp_q;
    end
  end

  AST_CLR_ON_TRIG: assert property (@(posedge clk) disable iff (rst)
    (trig_in && auto_rst_en) |=> (acc_q == '0)); // R6
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (hold_q && amp_q == '0) |=> (acc_q == '0)); // R7
  AST_NOTRIG_FREQ_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!freq_streamed && !trig_in && !pa_vld) |=> $stable(freq_q)); // R5
  AST_SHADOW_AMP: assert property (@(posedge clk) disable iff (rst)
    (trig_in && !pa_streamed) |=> (amp_q == $past(amp_shadow))); // R4
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
    (!auto_rst_en && !hold_q) |=> (acc_q == $past(acc_q) + $past(freq_q))); // R9

endmodule

// File: tb/trig_nco_tb.sv
module trig_nco_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] freq_in = '0, freq_shadow = '0;
  logic [15:0] phase_in = '0, phase_shadow = '0;
  logic [14:0] amp_in = '0, amp_shadow = '0;
  logic freq_vld = 0, pa_vld = 0, trig_in = 0, auto_rst_en = 0;
  logic freq_streamed = 0, pa_streamed = 0;
  logic [15:0] phase_out;
  logic [14:0] amp_out;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_acc = '0, m_freq = '0, lfsr = 32'h1ACE_B00C;
  logic [15:0] m_ph = '0, m_pout = '0;
  logic [14:0] m_amp = '0, m_aout = '0;
  logic m_hold = 1'b0;

  always #5 clk = ~clk;

  trig_nco u_dut (
    .clk(clk), .rst(rst), .freq_in(freq_in), .freq_vld(freq_vld),
    .phase_in(phase_in), .amp_in(amp_in), .pa_vld(pa_vld), .trig_in(trig_in),
    .auto_rst_en(auto_rst_en), .freq_shadow(freq_shadow),
    .phase_shadow(phase_shadow), .amp_shadow(amp_shadow),
    .freq_streamed(freq_streamed), .pa_streamed(pa_streamed),
    .phase_out(phase_out), .amp_out(amp_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic tg;
    tg = trig_in | (pa_streamed & pa_vld & (amp_in == 0) & phase_in[0]);
    if (rst) begin
      m_acc = 0; m_freq = 0; m_ph = 0; m_amp = 0; m_hold = 0; m_pout = 0; m_aout = 0;
    end else begin
      m_pout = m_acc[31:16] + m_ph;
      m_aout = m_amp;
      if (auto_rst_en && tg) m_acc = 0;
      else if (!m_hold || m_amp != 0) m_acc = m_acc + m_freq;
      if (auto_rst_en && tg) m_hold = 1;
      else if (m_amp != 0) m_hold = 0;
      if (freq_streamed) begin if (freq_vld) m_freq = freq_in; end
      else if (tg) m_freq = freq_shadow;
      if (pa_streamed) begin if (pa_vld) begin m_ph = phase_in; m_amp = amp_in; end end
      else if (tg) begin m_ph = phase_shadow; m_amp = amp_shadow; end
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " phase"}, {16'h0, phase_out}, {16'h0, m_pout});
    chk({tag, " amp"}, {17'h0, amp_out}, {17'h0, m_aout});
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R1"); step("R1");
    rst = 0;
    step("R1");
    chk("R1 phase zero", {16'h0, phase_out}, 0);

    // R2 R3 closed form: streamed freq 0x0100_0000, offset 0x40
    freq_streamed = 1; freq_vld = 1; freq_in = 32'h0100_0000;
    pa_streamed = 1; pa_vld = 1; phase_in = 16'h0040; amp_in = 15'd5;
    for (int n = 1; n <= 300; n++) begin
      step("R2");
      if (n >= 2) chk("R3 closed form", {16'h0, phase_out}, ((n - 2) * 256 + 64) & 32'hFFFF);
    end
    chk("R10 amp", {17'h0, amp_out}, 5);

    // R7 hold: external trigger with auto-reset, shadow amplitude zero
    pa_streamed = 0; pa_vld = 0; amp_shadow = 0; phase_shadow = 16'h1234;
    auto_rst_en = 1; trig_in = 1;
    step("R6"); trig_in = 0;
    for (int i = 0; i < 6; i++) step("R7");
    chk("R7 held phase", {16'h0, phase_out}, 32'h1234);
    pa_streamed = 1; pa_vld = 1; amp_in = 15'd9; phase_in = 0;
    for (int i = 0; i < 5; i++) step("R7");

    // R8 stream trigger decode
    amp_in = 0; phase_in = 16'h0002;
    step("R8"); step("R8"); step("R8");
    amp_in = 0; phase_in = 16'h0001;
    step("R8"); step("R8");
    chk("R8 cleared", {16'h0, phase_out}, 32'h0001);
    amp_in = 15'd3; step("R8"); step("R8");

    // sweep of source flags, auto-reset and trigger sources
    for (int cfg = 0; cfg < 16; cfg++) begin
      freq_streamed = cfg[0]; pa_streamed = cfg[1]; auto_rst_en = cfg[2];
      for (int i = 0; i < 60; i++) begin
        lfsr = nxt(lfsr); freq_in = lfsr; freq_vld = lfsr[3];
        lfsr = nxt(lfsr); phase_in = lfsr[15:0];
        amp_in = lfsr[20] ? 15'd0 : lfsr[30:16]; pa_vld = lfsr[7];
        lfsr = nxt(lfsr); freq_shadow = lfsr;
        lfsr = nxt(lfsr); phase_shadow = lfsr[15:0];
        amp_shadow = (cfg[3] && lfsr[9]) ? 15'd0 : lfsr[30:16];
        trig_in = (lfsr[5:3] == 3'd0);
        if (trig_in) step(auto_rst_en ? "R6" : "R9");
        else if (!freq_streamed || !pa_streamed) step("R5");
        else step("R4");
      end
    end
    trig_in = 0;

    // R1 synchronous reset mid-run
    rst = 1; step("R1"); rst = 0; freq_vld = 0; pa_vld = 0;
    freq_streamed = 0; pa_streamed = 0;
    step("R1");
    chk("R1 restart", {16'h0, phase_out}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule